// File: doc/BRIEF.md
# Wake-from-Sleep Reset Sequencer

This block controls how a small controller leaves its low-power sleep state. When the core asks to sleep, the block records the current value of a group of watched input pins. It then holds the core stopped until one of two events occurs: a synchronized pin value differs from the recorded value, or the external clear input is asserted. Either event starts a full reset. The reset cycle pulses a direction-reset output, which returns every port direction bit to input and so releases any outputs that were being driven. After that cycle the block counts an oscillator-settling delay. The length of the delay is chosen from four values by a select field.

Once the delay has elapsed, the block raises the core-run enable. The core treats the rising edge of that enable as the start of execution at its reset vector. The delay is counted in ticks of a separate timing enable, and the four tick counts are parameters. A cause flag shows whether the last wake came from the clear or from a pin change. The flag stays valid until the core next enters sleep. The clear input is synchronous to the clock and takes effect in any state, including normal running.

Top module: `wake_reset_seq`

## Requirements
- R1: While `rst_n` is low, `dir_reset` is 1 and `core_run` is 0. After release, the block makes one more reset cycle, then settles, then runs.
- R2: When `sleep_req` is 1 while running, `core_run` is 0 from the next cycle. The synchronized pin value at that edge is kept as the sleep snapshot.
- R3: During sleep, a change on any one watched pin raises `dir_reset` on the third rising edge after the change. Two of those edges are the two-flop synchronizer and one is the compare.
- R4: During sleep, if the pins keep their snapshot value, the block stays asleep with `core_run` and `dir_reset` both 0.
- R5: When `ext_clr` is 1, `dir_reset` is 1 from the next cycle in every state. It stays 1 for as long as `ext_clr` is held.
- R6: A wake with no held clear gives exactly one cycle of `dir_reset`. `core_run` is never 1 in the same cycle as `dir_reset`.
- R7: The settling time is the tick count selected by `dly_sel`, which is sampled in the reset cycle: 0 selects `T0`, 1 selects `T1`, 2 selects `T2` and 3 selects `T3`.
- R8: Only cycles with `tick` = 1 advance the settling count. The delay stops while `tick` is 0.
- R9: `core_run` rises in the cycle after the last settling tick, and stays 1 until a sleep request or a clear.
- R10: `wake_cause` is 1 after a clear-caused wake and 0 after a pin-change wake. It keeps that value while running and is cleared to 0 on sleep entry.
- R11: A `sleep_req` that arrives during settling is dropped. It does not stop the core from starting, and the core stays running afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | Timing enable that advances the settling count |
| sleep_req | input | 1 | Sleep request from the running core |
| wake_pins | input | W | Watched port pins (asynchronous) |
| ext_clr | input | 1 | External clear (synchronous, active high) |
| dly_sel | input | 2 | Settling-delay select |
| core_run | output | 1 | Core execution enable |
| dir_reset | output | 1 | Forces port directions to input while high |
| wake_cause | output | 1 | 1 = last wake was a clear, 0 = pin change |

## Verification
The vector table wakes the block once for each delay select, using both wake sources and several pin patterns: a single low bit, a single high bit, all bits and a mixed mask. The wake latency (three cycles versus one) separates pin wakes from clear wakes. The measured settling length shows whether each select value reaches the correct tick count. Directed cases cover the following:
- a long sleep with stable pins, which separates true change detection from false wakes;
- a stalled tick, which shows that only ticks advance the count;
- a held clear;
- a sleep request made during settling.

// File: rtl/wake_reset_seq.sv
module wake_reset_seq #(
  parameter int W  = 8,
  parameter int T0 = 300,
  parameter int T1 = 16000,
  parameter int T2 = 60000,
  parameter int T3 = 960000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         sleep_req,
  input  logic [W-1:0] wake_pins,
  input  logic         ext_clr,
  input  logic [1:0]   dly_sel,
  output logic         core_run,
  output logic         dir_reset,
  output logic         wake_cause
);
  localparam int TM01 = (T0 > T1) ? T0 : T1;
  localparam int TM23 = (T2 > T3) ? T2 : T3;
  localparam int TMAX = (TM01 > TM23) ? TM01 : TM23;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_RST, S_SETTLE, S_RUN, S_SLEEP} st_t;

  st_t           st;
  logic [CW-1:0] cnt, lim, sel_lim;
  logic [W-1:0]  s1, s2, snap;

  always_comb
    case (dly_sel)
      2'd0:    sel_lim = CW'(T0);
      2'd1:    sel_lim = CW'(T1);
      2'd2:    sel_lim = CW'(T2);
      default: sel_lim = CW'(T3);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_RST; cnt <= '0; lim <= '0; snap <= '0;
      s1 <= '0; s2 <= '0; wake_cause <= 1'b0;
    end else begin
      s1 <= wake_pins;
      s2 <= s1;
      if (ext_clr) begin
        st <= S_RST;
        wake_cause <= 1'b1;
      end else
        case (st)
          S_RST: begin
            st  <= S_SETTLE;
            cnt <= '0;
            lim <= sel_lim;
          end
          S_SETTLE:
            if (tick) begin
              if (cnt == lim - CW'(1)) st <= S_RUN;
              else cnt <= cnt + CW'(1);
            end
          S_RUN:
            if (sleep_req) begin
              st <= S_SLEEP;
              snap <= s2;
              wake_cause <= 1'b0;
            end
          S_SLEEP:
            if (s2 != snap) begin
              st <= S_RST;
              wake_cause <= 1'b0;
            end
        endcase
    end

  assign core_run  = (st == S_RUN);
  assign dir_reset = (st == S_RST);

  p_no_run_in_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_run && dir_reset));
  p_sleep_stops_core_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_run && sleep_req && !ext_clr |=> !core_run && !dir_reset);
  p_clear_resets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clr |=> dir_reset && wake_cause);
  p_run_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run) |-> $past(tick));
  p_settle_no_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SETTLE && !ext_clr |=> st != S_SLEEP);
  p_count_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_SETTLE |-> cnt < lim);
endmodule

// File: tb/wake_reset_seq_test.sv
module wake_reset_seq_test;
  localparam int W = 8;
  localparam int T0 = 2, T1 = 3, T2 = 5, T3 = 7;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, sleep_req = 1'b0, ext_clr = 1'b0;
  logic [W-1:0] wake_pins = 8'hA5;
  logic [1:0] dly_sel = 2'd0;
  logic core_run, dir_reset, wake_cause;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wake_reset_seq #(.W(W), .T0(T0), .T1(T1), .T2(T2), .T3(T3)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep_req(sleep_req),
    .wake_pins(wake_pins), .ext_clr(ext_clr), .dly_sel(dly_sel),
    .core_run(core_run), .dir_reset(dir_reset), .wake_cause(wake_cause));

  // {dly_sel[1:0], use_clear, pin_mask[7:0]}
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 1'b0, 8'h01}, {2'd1, 1'b1, 8'h00}, {2'd2, 1'b0, 8'h80},
    {2'd3, 1'b1, 8'h00}, {2'd0, 1'b1, 8'h00}, {2'd1, 1'b0, 8'hFF},
    {2'd2, 1'b1, 8'h00}, {2'd3, 1'b0, 8'h5A}};

  function automatic int lim_of(input logic [1:0] s);
    return (s == 0) ? T0 : (s == 1) ? T1 : (s == 2) ? T2 : T3;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_sleep();
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
  endtask

  task automatic wake_measure(output int lat, output int dr, output int settle);
    lat = 0; dr = 0; settle = 0;
    for (int k = 1; k <= 20; k++) begin
      step(1);
      if (dir_reset) begin lat = k; ext_clr = 1'b0; break; end
    end
    dr = 1;
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (dir_reset) dr++; else break;
    end
    settle = 1;
    for (int k = 0; k < 40; k++) begin
      step(1);
      if (core_run) break; else settle++;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, dr, settle;
    step(3);
    chk("R1 dir_reset in reset", dir_reset, 1);
    chk("R1 core_run in reset", core_run, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset cycle over", dir_reset, 0);
    step(T0 - 1);
    chk("R1 still settling", core_run, 0);
    step(1);
    chk("R9 running after settle", core_run, 1);

    foreach (VEC[i]) begin
      dly_sel = VEC[i][10:9];
      go_sleep();
      chk("R2 core stopped on sleep", core_run, 0);
      chk("R10 cause cleared on sleep", wake_cause, 0);
      if (VEC[i][8]) ext_clr = 1'b1;
      else wake_pins = wake_pins ^ VEC[i][7:0];
      wake_measure(lat, dr, settle);
      chk(VEC[i][8] ? "R5 clear latency" : "R3 pin latency", lat, VEC[i][8] ? 1 : 3);
      chk("R6 one reset cycle", dr, 1);
      chk("R7 settle length", settle, lim_of(VEC[i][10:9]));
      chk("R10 wake cause", wake_cause, VEC[i][8]);
    end

    dly_sel = 2'd0;
    go_sleep();
    step(15);
    chk("R4 stays asleep run", core_run, 0);
    chk("R4 stays asleep reset", dir_reset, 0);
    wake_pins = wake_pins ^ 8'h10;
    step(2);
    chk("R3 no wake before sync", dir_reset, 0);
    step(1);
    chk("R3 wake after sync", dir_reset, 1);
    step(1 + T0);
    chk("R9 running", core_run, 1);

    ext_clr = 1'b1; tick = 1'b0;
    step(1);
    chk("R5 clear while running", dir_reset, 1);
    step(4);
    chk("R5 held clear keeps reset", dir_reset, 1);
    ext_clr = 1'b0;
    step(1);
    chk("R6 reset released", dir_reset, 0);
    step(20);
    chk("R8 no progress without tick", core_run, 0);
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    tick = 1'b1;
    step(T0 - 1);
    chk("R8 settling with ticks", core_run, 0);
    step(1);
    chk("R11 sleep during settle ignored", core_run, 1);
    step(5);
    chk("R11 still running", core_run, 1);
    chk("R10 cause held while running", wake_cause, 1);
    go_sleep();
    chk("R10 cause cleared at sleep entry", wake_cause, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule